// File: doc/BRIEF.md
# Per-Frame FIFO Service Sequencer

This block walks the configured FIFO channels once per frame and moves one byte per channel direction between a FIFO and a switching buffer. A frame begins with a one-cycle `frame_start` pulse. From the next cycle on, the sequencer presents one service step per clock. A transmit step pops a byte from the addressed FIFO and writes it into that FIFO's slot of the transmit switching buffer. A receive step reads that slot from the receive switching buffer and pushes the byte into the FIFO. Both switching buffers share a single slot address. The FIFO storage and the switching buffers live outside the block: the sequencer only drives their strobes and addresses.

Two orders are available. In ascending order each active FIFO is served transmit first, then receive, from FIFO 0 upward. In list order a programmable list of FIFO/direction entries is walked in list position order. A per-FIFO slot map decides which buffer slot each FIFO uses, so a FIFO can be moved to another slot without touching anything else.

The configuration is copied into shadow registers on every `frame_start`, so a frame always runs on one consistent setup. Directions that are disabled, and FIFOs at or above the active count, cost no cycle. Two sticky flags record events that need attention. One reports a receive byte dropped because its FIFO was full. The other reports a frame start that arrived before the previous sequence had finished.

Top module: `fifo_frame_sequencer`

## Requirements
- R1: After reset `busy`, `overflow`, `overrun`, `txbuf_we`, `fifo_rd` and `fifo_wr` are all 0.
- R2: With `cfg_list_mode`=0, the steps follow the order FIFO0 transmit, FIFO0 receive, FIFO1 transmit, and so on upward, one step per clock. The first step is presented in the cycle after the clock edge that samples `frame_start`. `fifo_dir` is 0 for transmit and 1 for receive, and `busy` is 1 during every step.
- R3: A FIFO f takes part only if f < `cfg_fifo_cnt`. Its transmit step runs only if `cfg_tx_en[f]`=1, and its receive step only if `cfg_rx_en[f]`=1. Any other step is skipped, using no clock cycle and making no access.
- R4: On a transmit step, `buf_slot` = `cfg_map[5f+4:5f]` and `txbuf_we`=1. If the FIFO is not empty, `fifo_rd`=1 and `txbuf_wdata` = `fifo_rd_data`. If the FIFO is empty, `fifo_rd`=0 and `txbuf_wdata` = 8'hFF.
- R5: On a receive step, `buf_slot` is the mapped slot and `fifo_wr_data` = `rxbuf_rdata`. If the FIFO is not full, `fifo_wr`=1. If it is full, `fifo_wr`=0 and `overflow` becomes 1 and stays 1 until reset.
- R6: When several transmit steps of one frame map to the same slot, the slot ends the frame holding the byte of the step that came last in the sequence.
- R7: With `cfg_list_mode`=1, positions 0 to `cfg_list_len`-1 of `cfg_list` are served in position order. Entry p sits at `cfg_list[6p+5:6p]`: bits [5:1] hold the FIFO and bit 0 the direction. Entries that R3 rules out are skipped.
- R8: Configuration inputs are sampled only on a cycle with `frame_start`=1. Changing them during a frame does not alter that frame's steps.
- R9: A `frame_start` sampled while `busy`=1 restarts the sequence from its first step with freshly sampled configuration, and sets `overrun`. `overrun` then stays 1 until reset.
- R10: After the last step `busy`, `txbuf_we`, `fifo_rd` and `fifo_wr` stay 0 until the next `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | One-cycle frame pulse |
| cfg_list_mode | input | 1 | 0 ascending order, 1 list order |
| cfg_fifo_cnt | input | 6 | Number of active FIFOs |
| cfg_tx_en | input | 32 | Per-FIFO transmit enable |
| cfg_rx_en | input | 32 | Per-FIFO receive enable |
| cfg_map | input | 160 | Slot per FIFO, 5 bits each |
| cfg_list_len | input | 7 | Number of list entries used |
| cfg_list | input | 384 | Order list, 6 bits per entry |
| fifo_sel | output | 5 | FIFO addressed by the current step |
| fifo_dir | output | 1 | Direction of the current step |
| fifo_rd | output | 1 | Pop strobe for the transmit FIFO |
| fifo_empty | input | 1 | Addressed FIFO is empty |
| fifo_rd_data | input | 8 | Head byte of the addressed FIFO |
| fifo_wr | output | 1 | Push strobe for the receive FIFO |
| fifo_full | input | 1 | Addressed FIFO is full |
| fifo_wr_data | output | 8 | Byte pushed into the FIFO |
| buf_slot | output | 5 | Switching-buffer slot address |
| txbuf_we | output | 1 | Transmit buffer write strobe |
| txbuf_wdata | output | 8 | Transmit buffer write byte |
| rxbuf_rdata | input | 8 | Receive buffer byte at `buf_slot` |
| busy | output | 1 | A service step is presented |
| overflow | output | 1 | Sticky dropped-receive-byte flag |
| overrun | output | 1 | Sticky early-frame-start flag |

## Verification
The bench goes after slot collisions, where several FIFOs share one slot. A design that served FIFOs in the wrong order would leave an earlier writer's byte, or an idle byte that should have been overwritten, in the slot. It also tests sparse enables and active counts of zero or below 32; a design that spent a cycle on a skipped step would shift every later step by one cycle. Other cases are list entries that repeat, run out of order or point past the active count, a configuration change in the middle of a frame, which a design without shadow registers would apply at once, and a frame start in the middle of a sequence, which must both restart the order and raise the sticky flag. Empty transmit FIFOs and full receive FIFOs check the idle byte and the drop path.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } dir_e;

  // A step is live when its FIFO is inside the active range and its direction is on.
  function automatic logic lane_live(input int fifo, input logic dir, input int active,
                                     input logic tx_on, input logic rx_on);
    return (fifo < active) && (dir ? rx_on : tx_on);
  endfunction

endpackage

// File: rtl/fsq_shadow.sv
module fsq_shadow #(
  parameter int NUM_FIFO = 32,
  parameter int SLOT_W   = 5,
  parameter int NUM_POS  = 64,
  parameter int ENT_W    = 6,
  parameter int CNT_W    = 6,
  parameter int LEN_W    = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic                      in_mode,
  input  logic [CNT_W-1:0]          in_cnt,
  input  logic [NUM_FIFO-1:0]       in_tx_en,
  input  logic [NUM_FIFO-1:0]       in_rx_en,
  input  logic [NUM_FIFO*SLOT_W-1:0] in_map,
  input  logic [LEN_W-1:0]          in_len,
  input  logic [NUM_POS*ENT_W-1:0]  in_list,
  output logic                      sh_mode,
  output logic [CNT_W-1:0]          sh_cnt,
  output logic [NUM_FIFO-1:0]       sh_tx_en,
  output logic [NUM_FIFO-1:0]       sh_rx_en,
  output logic [NUM_FIFO*SLOT_W-1:0] sh_map,
  output logic [LEN_W-1:0]          sh_len,
  output logic [NUM_POS*ENT_W-1:0]  sh_list
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_mode  <= 1'b0;
      sh_cnt   <= '0;
      sh_tx_en <= '0;
      sh_rx_en <= '0;
      sh_map   <= '0;
      sh_len   <= '0;
      sh_list  <= '0;
    end else if (load) begin
      sh_mode  <= in_mode;
      sh_cnt   <= in_cnt;
      sh_tx_en <= in_tx_en;
      sh_rx_en <= in_rx_en;
      sh_map   <= in_map;
      sh_len   <= in_len;
      sh_list  <= in_list;
    end
  end

endmodule

// File: rtl/fsq_order.sv
module fsq_order #(
  parameter int NUM_FIFO = 32,
  parameter int NUM_POS  = 64,
  parameter int FIFO_W   = 5,
  parameter int POS_W    = 6,
  parameter int PTR_W    = 7,
  parameter int ENT_W    = 6,
  parameter int CNT_W    = 6,
  parameter int LEN_W    = 7
) (
  input  logic                     list_mode,
  input  logic [CNT_W-1:0]         cnt,
  input  logic [NUM_FIFO-1:0]      tx_en,
  input  logic [NUM_FIFO-1:0]      rx_en,
  input  logic [LEN_W-1:0]         len,
  input  logic [NUM_POS*ENT_W-1:0] list,
  input  logic [PTR_W-1:0]         ptr,
  output logic                     found,
  output logic [POS_W-1:0]         pos,
  output logic [FIFO_W-1:0]        fifo,
  output logic                     dir
);

  logic [NUM_POS-1:0] valid;
  logic [NUM_POS-1:0] above;
  logic [ENT_W-1:0]   ent_c;

  // Lowest set bit of a position vector.
  function automatic logic [POS_W-1:0] lowest_set(input logic [NUM_POS-1:0] v);
    logic [POS_W-1:0] idx;
    idx = '0;
    for (int i = NUM_POS - 1; i >= 0; i--) begin
      if (v[i]) idx = POS_W'(i);
    end
    return idx;
  endfunction

  for (genvar p = 0; p < NUM_POS; p++) begin : g_pos
    logic [ENT_W-1:0]  ent;
    logic [FIFO_W-1:0] f;
    logic              d;
    logic              in_range;
    assign ent      = list[p*ENT_W +: ENT_W];
    assign f        = list_mode ? ent[ENT_W-1:1] : FIFO_W'(p / 2);
    assign d        = list_mode ? ent[0] : ((p % 2) == 1);
    assign in_range = !list_mode || (p < int'(len));
    assign valid[p] = in_range &&
                      fsq_pkg::lane_live(int'(f), d, int'(cnt), tx_en[f], rx_en[f]);
  end

  // Keep only live positions at or after the pointer.
  assign above = valid & ~((NUM_POS'(1) << ptr) - NUM_POS'(1));
  assign found = |above;
  assign pos   = lowest_set(above);
  assign ent_c = list[pos*ENT_W +: ENT_W];
  assign fifo  = list_mode ? ent_c[ENT_W-1:1] : pos[POS_W-1:1];
  assign dir   = list_mode ? ent_c[0] : pos[0];

endmodule

// File: rtl/fsq_xfer.sv
module fsq_xfer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              dir,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_rd_data,
  input  logic              fifo_full,
  input  logic [DATA_W-1:0] rxbuf_rdata,
  output logic              fifo_rd,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_wr_data,
  output logic              txbuf_we,
  output logic [DATA_W-1:0] txbuf_wdata,
  output logic              overflow
);

  logic tx_step, rx_step, rx_drop;

  function automatic logic [DATA_W-1:0] pick_tx(input logic empty, input logic [DATA_W-1:0] d);
    return empty ? {DATA_W{1'b1}} : d;
  endfunction

  assign tx_step      = step && (dir == fsq_pkg::DIR_TX);
  assign rx_step      = step && (dir == fsq_pkg::DIR_RX);
  assign txbuf_we     = tx_step;
  assign fifo_rd      = tx_step && !fifo_empty;
  assign txbuf_wdata  = pick_tx(fifo_empty, fifo_rd_data);
  assign rx_drop      = rx_step && fifo_full;
  assign fifo_wr      = rx_step && !fifo_full;
  assign fifo_wr_data = rxbuf_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overflow <= 1'b0;
    else        overflow <= overflow | rx_drop;
  end

  // R5
  rx_drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !fifo_full);
  // R5
  overflow_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> overflow);
  // R5
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R4
  one_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(txbuf_we && fifo_wr));

endmodule

// File: rtl/fifo_frame_sequencer.sv
module fifo_frame_sequencer #(
  parameter int NUM_FIFO = 32,
  parameter int NUM_SLOT = 32,
  parameter int DATA_W   = 8,
  localparam int FIFO_W  = $clog2(NUM_FIFO),
  localparam int SLOT_W  = $clog2(NUM_SLOT),
  localparam int NUM_POS = 2 * NUM_FIFO,
  localparam int POS_W   = $clog2(NUM_POS),
  localparam int PTR_W   = POS_W + 1,
  localparam int ENT_W   = FIFO_W + 1,
  localparam int CNT_W   = $clog2(NUM_FIFO + 1),
  localparam int LEN_W   = $clog2(NUM_POS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_start,
  input  logic                       cfg_list_mode,
  input  logic [CNT_W-1:0]           cfg_fifo_cnt,
  input  logic [NUM_FIFO-1:0]        cfg_tx_en,
  input  logic [NUM_FIFO-1:0]        cfg_rx_en,
  input  logic [NUM_FIFO*SLOT_W-1:0] cfg_map,
  input  logic [LEN_W-1:0]           cfg_list_len,
  input  logic [NUM_POS*ENT_W-1:0]   cfg_list,
  output logic [FIFO_W-1:0]          fifo_sel,
  output logic                       fifo_dir,
  output logic                       fifo_rd,
  input  logic                       fifo_empty,
  input  logic [DATA_W-1:0]          fifo_rd_data,
  output logic                       fifo_wr,
  input  logic                       fifo_full,
  output logic [DATA_W-1:0]          fifo_wr_data,
  output logic [SLOT_W-1:0]          buf_slot,
  output logic                       txbuf_we,
  output logic [DATA_W-1:0]          txbuf_wdata,
  input  logic [DATA_W-1:0]          rxbuf_rdata,
  output logic                       busy,
  output logic                       overflow,
  output logic                       overrun
);

  logic                       sh_mode;
  logic [CNT_W-1:0]           sh_cnt;
  logic [NUM_FIFO-1:0]        sh_tx_en, sh_rx_en;
  logic [NUM_FIFO*SLOT_W-1:0] sh_map;
  logic [LEN_W-1:0]           sh_len;
  logic [NUM_POS*ENT_W-1:0]   sh_list;

  logic             run;
  logic [PTR_W-1:0] ptr;
  logic             found;
  logic [POS_W-1:0] step_pos;
  logic [FIFO_W-1:0] cur_fifo;
  logic             cur_dir;
  logic             step;

  fsq_shadow #(.NUM_FIFO(NUM_FIFO), .SLOT_W(SLOT_W), .NUM_POS(NUM_POS),
               .ENT_W(ENT_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(frame_start),
    .in_mode(cfg_list_mode), .in_cnt(cfg_fifo_cnt), .in_tx_en(cfg_tx_en),
    .in_rx_en(cfg_rx_en), .in_map(cfg_map), .in_len(cfg_list_len), .in_list(cfg_list),
    .sh_mode(sh_mode), .sh_cnt(sh_cnt), .sh_tx_en(sh_tx_en), .sh_rx_en(sh_rx_en),
    .sh_map(sh_map), .sh_len(sh_len), .sh_list(sh_list)
  );

  fsq_order #(.NUM_FIFO(NUM_FIFO), .NUM_POS(NUM_POS), .FIFO_W(FIFO_W), .POS_W(POS_W),
              .PTR_W(PTR_W), .ENT_W(ENT_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_order (
    .list_mode(sh_mode), .cnt(sh_cnt), .tx_en(sh_tx_en), .rx_en(sh_rx_en),
    .len(sh_len), .list(sh_list), .ptr(ptr),
    .found(found), .pos(step_pos), .fifo(cur_fifo), .dir(cur_dir)
  );

  assign step     = run && found;
  assign busy     = step;
  assign fifo_sel = cur_fifo;
  assign fifo_dir = cur_dir;
  assign buf_slot = sh_map[cur_fifo*SLOT_W +: SLOT_W];

  fsq_xfer #(.DATA_W(DATA_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .step(step), .dir(cur_dir),
    .fifo_empty(fifo_empty), .fifo_rd_data(fifo_rd_data), .fifo_full(fifo_full),
    .rxbuf_rdata(rxbuf_rdata), .fifo_rd(fifo_rd), .fifo_wr(fifo_wr),
    .fifo_wr_data(fifo_wr_data), .txbuf_we(txbuf_we), .txbuf_wdata(txbuf_wdata),
    .overflow(overflow)
  );

  // Step pointer: restart on a frame pulse, otherwise advance past the served position.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      ptr     <= '0;
      overrun <= 1'b0;
    end else if (frame_start) begin
      run <= 1'b1;
      ptr <= '0;
      if (step) overrun <= 1'b1;
    end else if (step) begin
      ptr <= PTR_W'(step_pos) + PTR_W'(1);
    end else begin
      run <= 1'b0;
    end
  end

  // R2
  order_ascends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !frame_start |=> !busy || (step_pos > $past(step_pos)));
  // R9
  overrun_on_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && busy |=> overrun);
  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !txbuf_we && !fifo_rd && !fifo_wr);
  // R10
  stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !frame_start |=> !busy);

endmodule

// File: tb/sim_fifo_frame_sequencer.sv
module sim_fifo_frame_sequencer;
  localparam int NF = 32;
  localparam int NS = 32;
  localparam int NP = 64;
  localparam int SW = 5;
  localparam int EW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  always #10 clk = ~clk;

  logic              list_mode;
  logic [5:0]        fifo_cnt;
  logic [NF-1:0]     tx_en, rx_en;
  logic [NF*SW-1:0]  map_v;
  logic [6:0]        list_len;
  logic [NP*EW-1:0]  list_v;
  logic [4:0]        b_map [NF];
  logic [5:0]        b_list [NP];

  logic [4:0] fifo_sel, buf_slot;
  logic       fifo_dir, fifo_rd, fifo_wr, fifo_empty, fifo_full, txbuf_we;
  logic [7:0] fifo_rd_data, fifo_wr_data, txbuf_wdata, rxbuf_rdata;
  logic       busy, overflow, overrun;

  int         tx_cnt [NF];
  logic       rx_full [NF];
  logic [7:0] rxbuf [NS];
  logic [7:0] txbuf [NS];
  logic [7:0] exp_txbuf [NS];
  logic [4:0] s_map [NF];
  int         ef [NP];
  int         ed [NP];
  int         en_n;
  logic       exp_ovf = 1'b0;
  logic       exp_ovr = 1'b0;
  int         checks = 0;
  int         fails = 0;

  always_comb begin
    for (int f = 0; f < NF; f++) map_v[f*SW +: SW] = b_map[f];
    for (int p = 0; p < NP; p++) list_v[p*EW +: EW] = b_list[p];
  end

  function automatic logic [7:0] tx_byte(input int f, input int c);
    return 8'((f * 37 + c * 11 + 5) & 255);
  endfunction

  assign fifo_empty   = (tx_cnt[fifo_sel] == 0);
  assign fifo_rd_data = tx_byte(int'(fifo_sel), tx_cnt[fifo_sel]);
  assign fifo_full    = rx_full[fifo_sel];
  assign rxbuf_rdata  = rxbuf[buf_slot];

  always @(posedge clk) begin
    if (fifo_rd) tx_cnt[fifo_sel] <= tx_cnt[fifo_sel] - 1;
    if (txbuf_we) txbuf[buf_slot] <= txbuf_wdata;
  end

  fifo_frame_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_list_mode(list_mode), .cfg_fifo_cnt(fifo_cnt), .cfg_tx_en(tx_en),
    .cfg_rx_en(rx_en), .cfg_map(map_v), .cfg_list_len(list_len), .cfg_list(list_v),
    .fifo_sel(fifo_sel), .fifo_dir(fifo_dir), .fifo_rd(fifo_rd),
    .fifo_empty(fifo_empty), .fifo_rd_data(fifo_rd_data), .fifo_wr(fifo_wr),
    .fifo_full(fifo_full), .fifo_wr_data(fifo_wr_data), .buf_slot(buf_slot),
    .txbuf_we(txbuf_we), .txbuf_wdata(txbuf_wdata), .rxbuf_rdata(rxbuf_rdata),
    .busy(busy), .overflow(overflow), .overrun(overrun)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic live(input int f, input int d);
    return (f < int'(fifo_cnt)) && ((d == 1) ? rx_en[f] : tx_en[f]);
  endfunction

  // Expected step list built from the configuration the next frame pulse will capture.
  task automatic build_seq();
    en_n = 0;
    for (int f = 0; f < NF; f++) s_map[f] = b_map[f];
    if (list_mode) begin
      for (int p = 0; p < int'(list_len); p++) begin
        int f = int'(b_list[p][5:1]);
        int d = int'(b_list[p][0]);
        if (live(f, d)) begin ef[en_n] = f; ed[en_n] = d; en_n++; end
      end
    end else begin
      for (int f = 0; f < NF; f++)
        for (int d = 0; d < 2; d++)
          if (live(f, d)) begin ef[en_n] = f; ed[en_n] = d; en_n++; end
    end
  endtask

  task automatic check_step(input int i, input string otag);
    int f = ef[i];
    int d = ed[i];
    logic [4:0] slot = s_map[f];
    chk(otag, 64'({busy, fifo_sel, fifo_dir}), 64'({1'b1, 5'(f), 1'(d)}));
    if (d == 0) begin
      logic emp = (tx_cnt[f] == 0);
      logic [7:0] data = emp ? 8'hFF : tx_byte(f, tx_cnt[f]);
      chk("R4", 64'({buf_slot, txbuf_we, txbuf_wdata, fifo_rd, fifo_wr}),
                64'({slot, 1'b1, data, !emp, 1'b0}));
      exp_txbuf[slot] = data;
    end else begin
      chk("R5", 64'({buf_slot, txbuf_we, fifo_wr, fifo_wr_data, fifo_rd}),
                64'({slot, 1'b0, !rx_full[f], rxbuf[slot], 1'b0}));
      if (rx_full[f]) exp_ovf = 1'b1;
    end
  endtask

  task automatic rand_cfg(input logic mode);
    list_mode = mode;
    fifo_cnt  = ($urandom_range(0, 3) == 0) ? 6'd32 : 6'($urandom_range(0, 32));
    tx_en     = $urandom | $urandom;
    rx_en     = $urandom | $urandom;
    list_len  = 7'($urandom_range(0, 64));
    for (int f = 0; f < NF; f++) b_map[f] = 5'($urandom_range(0, 31));
    for (int p = 0; p < NP; p++) b_list[p] = 6'($urandom);
  endtask

  task automatic rand_fifo();
    for (int f = 0; f < NF; f++) begin
      tx_cnt[f]  = $urandom_range(0, 2);
      rx_full[f] = ($urandom_range(0, 7) == 0);
    end
  endtask

  task automatic run_frame(input string otag, input int abort_at, input int perturb_at);
    int i = 0;
    int ab = abort_at;
    int mism = 0;
    build_seq();
    for (int s = 0; s < NS; s++) exp_txbuf[s] = txbuf[s];
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    while (i < en_n) begin
      check_step(i, otag);
      if (i == perturb_at) rand_cfg(1'($urandom_range(0, 1)));
      if (i == ab) begin
        frame_start = 1'b1;
        exp_ovr = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        chk("R9", 64'(overrun), 64'(1));
        build_seq();
        ab = -1;
        i = 0;
      end else begin
        @(negedge clk);
        i++;
      end
    end
    chk("R10", 64'({busy, txbuf_we, fifo_rd, fifo_wr}), 64'(0));
    for (int s = 0; s < NS; s++) if (txbuf[s] !== exp_txbuf[s]) mism++;
    chk("R6", 64'(mism), 64'(0));
    chk("R5", 64'(overflow), 64'(exp_ovf));
    chk("R9", 64'(overrun), 64'(exp_ovr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R10 act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7151));
    list_mode = 1'b0; fifo_cnt = '0; tx_en = '0; rx_en = '0; list_len = '0;
    for (int f = 0; f < NF; f++) begin b_map[f] = 5'(f); tx_cnt[f] = 0; rx_full[f] = 1'b0; end
    for (int p = 0; p < NP; p++) b_list[p] = '0;
    for (int s = 0; s < NS; s++) begin rxbuf[s] = 8'($urandom); txbuf[s] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 64'({busy, overflow, overrun, txbuf_we, fifo_rd, fifo_wr}), 64'(0));

    // Full ascending frame, every FIFO holding one byte, nothing full.
    fifo_cnt = 6'd32; tx_en = '1; rx_en = '1;
    for (int f = 0; f < NF; f++) tx_cnt[f] = 1;
    run_frame("R2", -1, -1);

    // R6: four FIFOs collide on slot 9; FIFO3 is last.
    fifo_cnt = 6'd4; tx_en = '1; rx_en = '0;
    for (int f = 0; f < 4; f++) begin b_map[f] = 5'd9; tx_cnt[f] = 1; end
    run_frame("R2", -1, -1);
    chk("R6", 64'(txbuf[9]), 64'(tx_byte(3, 1)));
    // Last writer is empty: idle byte must win.
    tx_cnt[0] = 1; tx_cnt[1] = 1; tx_cnt[2] = 1; tx_cnt[3] = 0;
    run_frame("R4", -1, -1);
    chk("R6", 64'(txbuf[9]), 64'(8'hFF));

    // R3: everything disabled, then zero active FIFOs.
    fifo_cnt = 6'd32; tx_en = '0; rx_en = '0;
    run_frame("R3", -1, -1);
    fifo_cnt = 6'd0; tx_en = '1; rx_en = '1;
    run_frame("R3", -1, -1);
    chk("R3", 64'(en_n), 64'(0));

    // R7: descending and repeated list entries, one past the active count.
    list_mode = 1'b1; fifo_cnt = 6'd8; tx_en = '1; rx_en = '1; list_len = 7'd4;
    b_list[0] = {5'd5, 1'b1}; b_list[1] = {5'd2, 1'b0};
    b_list[2] = {5'd20, 1'b0}; b_list[3] = {5'd5, 1'b0};
    for (int f = 0; f < NF; f++) tx_cnt[f] = 2;
    run_frame("R7", -1, -1);
    chk("R7", 64'(en_n), 64'(3));

    for (int k = 0; k < 10; k++) begin rand_cfg(1'b0); rand_fifo(); run_frame("R2,R3", -1, -1); end
    for (int k = 0; k < 10; k++) begin rand_cfg(1'b1); rand_fifo(); run_frame("R7", -1, -1); end

    // R8: configuration changes mid-frame, applied only on the next frame.
    list_mode = 1'b0; fifo_cnt = 6'd32; tx_en = '1; rx_en = '1; rand_fifo();
    run_frame("R8", -1, 3);
    rand_fifo();
    run_frame("R8", -1, -1);

    // R9: early frame pulse in the middle of a sequence.
    list_mode = 1'b0; fifo_cnt = 6'd32; tx_en = '1; rx_en = '1; rand_fifo();
    run_frame("R9", 5, -1);
    rand_fifo();
    run_frame("R9", -1, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule